// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Transceiver

This block moves one byte at a time over a three-wire synchronous serial link: a serial clock, a data output and a data input. Bits leave most-significant first on the data output while the same number of bits is collected from the data input, so every transfer is a full-duplex exchange. A small configuration byte selects where the serial clock comes from, its idle level and which clock edge launches and captures data.

The clock-select field serves two purposes. Seven of its codes divide the system clock by a power of two, and the block becomes the master that drives the serial clock. The eighth code hands clock ownership to an external device and makes the block a slave that follows the incoming clock. The polarity bit and the phase bit together give four timing types. The configuration byte can only be written while the interface enable is low.

Transmit bytes enter through a valid/ready port. The ready signal is high only while the block is enabled and no transfer is running, so a held valid waits until the link is free. Received bytes leave on a one-cycle valid pulse with no ready. The receiving side must take the byte in that cycle or read the held data output before the next pulse.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the configuration reads 00h, the serial clock output is high, the data output is high, tx_ready, rx_valid and sck_oe are low.
- R2: A configuration write takes effect only when en is low. A write while en is high leaves cfg_q unchanged. Layout: bits [2:0] clock select, bit 6 polarity, bit 7 phase; bits 5:3 always read 0.
- R3: For clock-select code k from 0 to 6 the block is master and drives sck_oe high while enabled. The serial clock period is 2^(k+1) system cycles, and the first serial-clock edge comes 2^k cycles after the accepting clock edge of the transfer.
- R4: Clock-select code 7 makes the block a slave. sck_oe is low, and bit timing follows sck_in through a two-stage synchronizer. sck_in must stay at least two system cycles in each level.
- R5: A transfer shifts eight bits, MSB first, out on so while capturing eight bits from si, MSB first.
- R6: The idle serial clock level is high for polarity 0 and low for polarity 1. The leading edge leaves idle and the trailing edge returns to it. With phase 0 (types 1 and 3), so changes on leading edges and si is captured on trailing edges.
- R7: With phase 1 (types 2 and 4), so presents bit 7 from the accepting clock edge. si is captured on leading edges and so advances on trailing edges.
- R8: rx_valid is high for exactly one cycle per transfer, after the eighth capture. rx_data then holds the received byte until the next one is complete.
- R9: tx_ready equals en with no transfer in progress. A transfer starts on a cycle where tx_valid and tx_ready are both high.
- R10: Dropping en aborts any transfer. From the next cycle the serial clock output sits at its idle level, so is high and tx_ready is low. The next transfer starts from bit 7 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Interface enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_q | output | 8 | Current configuration |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter free to accept a byte |
| tx_data | input | 8 | Byte to send |
| rx_valid | output | 1 | One-cycle pulse: received byte complete |
| rx_data | output | 8 | Last received byte |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | High when sck_out should drive the line |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, a 3-bit clock-select field and a two-stage synchronizer. These values make every divider code reachable, from divide-by-2 to the divide-by-128 setting at about a thousand cycles per byte, as well as the slave code. All four timing types are exercised, with bit-level models of the far end in both master and slave roles. Both the first-edge delay and the steady period are measured. An abort in the middle of a transfer and the locking of the configuration byte are covered by directed tests.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam int CSEL_W = 3;

  typedef struct packed {
    logic              phase;
    logic              pol;
    logic [CSEL_W-1:0] sel;
  } ssp_cfg_t;

  // serial clock rests high for polarity 0, low for polarity 1
  function automatic logic idle_lvl(input logic pol);
    return ~pol;
  endfunction

endpackage

// File: rtl/ssp_cfg_reg.sv
module ssp_cfg_reg
  import ssp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       wr,
  input  logic [7:0] wdata,
  output ssp_cfg_t   cfg,
  output logic [7:0] cfg_byte
);

  localparam int PHASE_BIT = 7;
  localparam int POL_BIT   = 6;

  ssp_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr && !en) begin
      cfg_q.phase <= wdata[PHASE_BIT];
      cfg_q.pol   <= wdata[POL_BIT];
      cfg_q.sel   <= wdata[CSEL_W-1:0];
    end
  end

  assign cfg = cfg_q;

  always_comb begin
    cfg_byte                = '0;
    cfg_byte[PHASE_BIT]     = cfg_q.phase;
    cfg_byte[POL_BIT]       = cfg_q.pol;
    cfg_byte[CSEL_W-1:0]    = cfg_q.sel;
  end

endmodule

// File: rtl/ssp_sck_unit.sv
module ssp_sck_unit
  import ssp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              start,
  input  logic [CSEL_W-1:0] sel,
  input  logic              pol,
  input  logic              expect_lead,
  input  logic              sck_in,
  output logic              evt,
  output logic              master,
  output logic              sck_drv
);

  localparam int HP_W = (1 << CSEL_W) - 2;
  localparam logic [CSEL_W-1:0] SLAVE_CODE = '1;

  logic [HP_W-1:0] hp_cnt;
  logic [HP_W-1:0] half_m1;
  logic            m_evt;
  logic            s_evt;
  logic            sck_q;
  logic            idle;

  assign master  = (sel != SLAVE_CODE);
  assign idle    = idle_lvl(pol);
  assign half_m1 = HP_W'((1 << sel) - 1);

  // master half-period divider
  assign m_evt = busy && (hp_cnt == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_cnt <= '0;
    end else if (start || !busy || m_evt) begin
      hp_cnt <= '0;
    end else begin
      hp_cnt <= hp_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b1;
    end else if (start) begin
      sck_q <= idle;
    end else if (master && m_evt) begin
      sck_q <= ~sck_q;
    end
  end

  assign sck_drv = (busy && master) ? sck_q : idle;

  // slave synchronizer and edge detect
  logic [SYNC_STAGES:0] sync_q;
  logic                 s_lvl;
  logic                 s_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], sck_in};
    end
  end

  assign s_lvl  = sync_q[SYNC_STAGES-1];
  assign s_edge = s_lvl ^ sync_q[SYNC_STAGES];
  assign s_evt  = busy && s_edge && ((s_lvl != idle) == expect_lead);

  assign evt = master ? m_evt : s_evt;

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              phase,
  input  logic              evt,
  input  logic              si,
  output logic              so,
  output logic              busy,
  output logic              expect_lead,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  localparam int N_EVT = 2 * DATA_W;
  localparam int EV_W  = $clog2(N_EVT);
  localparam logic [EV_W-1:0] LAST_EVT  = EV_W'(N_EVT - 1);
  localparam logic [EV_W-1:0] LAST_LEAD = EV_W'(N_EVT - 2);

  logic [EV_W-1:0]   ev_cnt;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic              last_evt;
  logic              sample;
  logic              shift_out;
  logic              last_sample;

  assign expect_lead = ~ev_cnt[0];
  assign last_evt    = (ev_cnt == LAST_EVT);
  assign sample      = phase ? expect_lead : ~expect_lead;
  assign shift_out   = phase ? (~expect_lead && !last_evt) : expect_lead;
  assign last_sample = phase ? (ev_cnt == LAST_LEAD) : last_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ev_cnt   <= '0;
      so       <= 1'b1;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (!en) begin
      busy     <= 1'b0;
      ev_cnt   <= '0;
      so       <= 1'b1;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        ev_cnt <= '0;
        if (phase) begin
          so    <= tx_data[DATA_W-1];
          tx_sr <= tx_data << 1;
        end else begin
          tx_sr <= tx_data;
        end
      end else if (busy && evt) begin
        ev_cnt <= last_evt ? '0 : ev_cnt + 1'b1;
        if (last_evt) begin
          busy <= 1'b0;
        end
        if (shift_out) begin
          so    <= tx_sr[DATA_W-1];
          tx_sr <= tx_sr << 1;
        end
        if (sample) begin
          rx_sr <= {rx_sr[DATA_W-2:0], si};
          if (last_sample) begin
            rx_data  <= {rx_sr[DATA_W-2:0], si};
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_q,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              so,
  input  logic              si
);

  ssp_cfg_t cfg;
  logic     busy;
  logic     start;
  logic     evt;
  logic     expect_lead;
  logic     master;

  ssp_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .cfg      (cfg),
    .cfg_byte (cfg_q)
  );

  assign tx_ready = en && !busy;
  assign start    = tx_valid && tx_ready;

  ssp_sck_unit #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sck (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .start       (start),
    .sel         (cfg.sel),
    .pol         (cfg.pol),
    .expect_lead (expect_lead),
    .sck_in      (sck_in),
    .evt         (evt),
    .master      (master),
    .sck_drv     (sck_out)
  );

  assign sck_oe = en && master;

  ssp_shifter #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .start       (start),
    .tx_data     (tx_data),
    .phase       (cfg.phase),
    .evt         (evt),
    .si          (si),
    .so          (so),
    .busy        (busy),
    .expect_lead (expect_lead),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid)
  );

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [7:0] cfg_q,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       sck_out,
  input logic       sck_oe,
  input logic       so
);

  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(cfg_q));

  a_r9_no_ready_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tx_ready);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r4_slave_released: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cfg_q[2:0] == 3'b111) |-> !sck_oe);

  a_r10_so_idle_after_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> so);

  a_r6_sck_idle_after_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sck_out == !cfg_q[6]));

endmodule

bind sync_serial_xcvr ssp_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .cfg_q    (cfg_q),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .sck_out  (sck_out),
  .sck_oe   (sck_oe),
  .so       (so)
);

// File: tb/sync_serial_xcvr_tb.sv
module sync_serial_xcvr_tb;

  localparam int CLK_P = 10;
  localparam int NVEC  = 7;
  // {cfg, tx byte, far-end reply byte}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 8'hA5, 8'h3C},   // type 1, div 2
    {8'h41, 8'h5A, 8'hC3},   // type 3, div 4
    {8'h82, 8'h81, 8'h7E},   // type 2, div 8
    {8'hC3, 8'h00, 8'hFF},   // type 4, div 16
    {8'h06, 8'h01, 8'h80},   // type 1, div 128
    {8'hC7, 8'h96, 8'h69},   // type 4, slave
    {8'h07, 8'h3C, 8'hA5}    // type 1, slave
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_q;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       sck_in = 1'b1;
  logic       sck_out;
  logic       sck_oe;
  logic       so;
  logic       si = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // far-end model state
  logic       ph;
  logic [7:0] reply;
  logic [7:0] got;
  int         lk;
  int         tk;

  sync_serial_xcvr u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .sck_in    (sck_in),
    .sck_out   (sck_out),
    .sck_oe    (sck_oe),
    .so        (so),
    .si        (si)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_wr    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // reaction of the far end to one serial clock edge (R6, R7)
  task automatic far_edge(input bit lead);
    if (lead) begin
      if (!ph) si = reply[7-lk];
      else     got[7-lk] = so;
      lk++;
    end else begin
      if (!ph)        got[7-tk] = so;
      else if (tk < 7) si = reply[6-tk];
      tk++;
    end
  endtask

  task automatic run_xfer(input logic [7:0] cfg, input logic [7:0] tx, input logic [7:0] rep);
    logic idle;
    bit   slave;
    int   half;
    int   n;
    int   nvalid;
    int   first_lead;
    int   second_lead;
    logic prev;
    string rq;
    en = 1'b0;
    @(negedge clk);
    idle   = ~cfg[6];
    ph     = cfg[7];
    slave  = (cfg[2:0] == 3'b111);
    half   = 1 << cfg[2:0];
    reply  = rep;
    got    = '0;
    lk     = 0;
    tk     = 0;
    sck_in = idle;
    si     = 1'b0;
    write_cfg(cfg);
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk(sck_oe == !slave, slave ? "R4 sck_oe" : "R3 sck_oe", sck_oe, !slave);
    if (ph) si = rep[7];
    tx_valid = 1'b1;
    tx_data  = tx;
    @(negedge clk);
    tx_valid = 1'b0;
    n = 1;
    nvalid = 0;
    first_lead = -1;
    second_lead = -1;
    chk(tx_ready == 1'b0, "R9 busy", tx_ready, 0);
    if (!slave) begin
      prev = idle;
      while (lk + tk < 16 && n < 3000) begin
        if (rx_valid) nvalid++;
        if (sck_out != prev) begin
          prev = sck_out;
          if (sck_out != idle) begin
            if (first_lead < 0) first_lead = n;
            else if (second_lead < 0) second_lead = n;
          end
          far_edge(sck_out != idle);
        end
        @(negedge clk);
        n++;
      end
      chk(first_lead == half + 1, "R3 first edge", first_lead, half + 1);
      chk(second_lead - first_lead == 2 * half, "R3 period", second_lead - first_lead, 2 * half);
      repeat (3) begin
        if (rx_valid) nvalid++;
        @(negedge clk);
      end
    end else begin
      for (int k = 0; k < 16; k++) begin
        repeat (4) begin
          if (rx_valid) nvalid++;
          @(negedge clk);
        end
        far_edge((k % 2) == 0);
        sck_in = ((k % 2) == 0) ? ~idle : idle;
      end
      repeat (8) begin
        if (rx_valid) nvalid++;
        @(negedge clk);
      end
    end
    rq = ph ? "R7 so bits" : "R6 so bits";
    chk(got == tx, rq, got, tx);
    chk(rx_data == rep, "R5 rx byte", rx_data, rep);
    chk(nvalid == 1, "R8 rx_valid pulses", nvalid, 1);
    chk(sck_out == idle, "R6 idle level", sck_out, idle);
    chk(tx_ready == 1'b1, "R9 ready after", tx_ready, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_q == 8'h00, "R1 cfg", cfg_q, 0);
    chk(sck_out == 1'b1, "R1 sck", sck_out, 1);
    chk(so == 1'b1, "R1 so", so, 1);
    chk(tx_ready == 1'b0, "R1 tx_ready", tx_ready, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(sck_oe == 1'b0, "R1 sck_oe", sck_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_xfer(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R2 configuration lock and reserved bits
    en = 1'b0;
    write_cfg(8'hFF);
    chk(cfg_q == 8'hC7, "R2 reserved bits", cfg_q, 8'hC7);
    en = 1'b1;
    @(negedge clk);
    chk(sck_oe == 1'b0, "R4 slave no drive", sck_oe, 0);
    write_cfg(8'h00);
    chk(cfg_q == 8'hC7, "R2 write while enabled", cfg_q, 8'hC7);
    en = 1'b0;
    write_cfg(8'h05);
    chk(cfg_q == 8'h05, "R2 write while disabled", cfg_q, 8'h05);

    // R10 abort mid transfer, then a clean restart
    write_cfg(8'h03);
    en = 1'b1;
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = 8'hF0;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (40) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(sck_out == 1'b1, "R10 sck idle", sck_out, 1);
    chk(so == 1'b1, "R10 so idle", so, 1);
    chk(tx_ready == 1'b0, "R10 tx_ready", tx_ready, 0);
    run_xfer(8'h03, 8'hC9, 8'h36);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule